// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an asynchronous static RAM of 128K words by 16 bits, split into a lower lane (bits 7:0) and an upper lane (bits 15:8). The host offers one word access at a time on a valid/ready request channel: a read/write flag, a 17-bit word address, a 2-bit lane enable and write data. The controller then plays out a read or write cycle on the memory pins, holding each phase for a number of clocks derived at elaboration time from nanosecond timing limits and the clock period. Each count is the limit divided by the clock period, rounded up, and never less than one.

The request channel obeys the usual rules: a request transfers on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the controller is idle. The host holds its fields stable while `req_valid` is high and not yet accepted. The response is a single-cycle `rsp_valid` pulse with no back-pressure; the host must take it when it appears. Read data stays on `rsp_rdata` until the next read completes.

The memory data bus is presented split: `sram_dq_out` with its enable `sram_dq_oe`, and `sram_dq_in` sampled from the pins. All memory controls are active low. While idle the chip enable is high and the memory is in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever idle, `sram_ce_n`, `sram_oe_n`, `sram_we_n`, `sram_ub_n` and `sram_lb_n` are high, `sram_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted on a rising edge with `req_valid` and `req_ready` high; its fields are captured then, so later changes on the request inputs have no effect, and `req_ready` stays low from acceptance until the controller is idle again.
- R3: During a read, `sram_ce_n` and `sram_oe_n` are low, `sram_we_n` is high, `sram_lb_n` equals the inverse of lane-enable bit 0 (lower lane, bits 7:0), `sram_ub_n` the inverse of bit 1 (upper lane, bits 15:8), and `sram_addr` holds the captured address for the whole access.
- R4: The read phase lasts the largest of the rounded-up cycle time, address access, chip-enable access, output-enable access and byte-strobe access counts; data is sampled on the edge that ends it and `rsp_valid` is high in the following cycle (with defaults, the 5th cycle after acceptance).
- R5: In read data, a lane whose enable bit was 0 returns zero; a read with enable 00 returns 0x0000.
- R6: During a write, `sram_ce_n` and `sram_we_n` are low, `sram_oe_n` is high, the strobes follow the lane enable as in R3, and `sram_dq_oe` is high exactly while `sram_we_n` is low, with `sram_dq_out` equal to the captured write data.
- R7: `sram_we_n` stays low for the larger of the write-pulse and data-setup counts, then rises while address, chip enable and strobes are unchanged; they are held for the data-hold count, after which `rsp_valid` pulses (with defaults, in the 9th cycle after acceptance) and the controller is idle in that same cycle.
- R8: A write with lane enable 00 leaves the memory word unchanged, and a single-lane write leaves the other lane unchanged.
- R9: After a read, all controls are deasserted and no request is accepted for the rounded-up high-impedance count (2 cycles by default), so `sram_dq_oe` never rises within that window after `sram_oe_n` rises.
- R10: `rsp_valid` is high for exactly one cycle per completed access.
- R11: An active-low reset asserted mid-access returns every output to the R1 state at once, and the next access after release completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_be | input | 2 | Lane enable, bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 17 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper-lane strobe, active low |
| sram_lb_n | output | 1 | Lower-lane strobe, active low |
| sram_dq_out | output | 16 | Data driven to the memory |
| sram_dq_oe | output | 1 | Enable for `sram_dq_out` |
| sram_dq_in | input | 16 | Data read from the memory pins |

## Verification
On every cycle the assertions check that the idle state keeps the memory in standby, that the controller drives the bus only inside a write pulse with output enable high, that the address never moves while chip enable is held, that write enable rises with address and strobes steady, that the bus-turnaround window is respected, and that each completion pulse lasts one cycle. The exact phase lengths, the sampled read data with lane masking, and the effect of partial or empty lane enables on stored data can only be shown by the bench's scenarios against its memory model, as can recovery from a reset in the middle of a write.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_TURN  = 3'd4
  } ctrl_state_t;

  // Clock count covering a time limit, rounded up, at least one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe #(
  parameter int unsigned LANES = 2
) (
  input  logic             active,
  input  logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] strobe_n
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strobe_n[g] = ~(active & lane_en[g]);
  end

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned LANE_W = DATA_W / LANES;

  assign dq_out = wdata;
  assign dq_oe  = drive;

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata[g*LANE_W +: LANE_W] <= '0;
      end else if (capture) begin
        rdata[g*LANE_W +: LANE_W] <= lane_en[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CLK_NS   = 20,
  parameter int unsigned T_RC_NS  = 70,
  parameter int unsigned T_AA_NS  = 70,
  parameter int unsigned T_ACE_NS = 70,
  parameter int unsigned T_DOE_NS = 35,
  parameter int unsigned T_BA_NS  = 35,
  parameter int unsigned T_HZ_NS  = 25,
  parameter int unsigned T_WP_NS  = 70,
  parameter int unsigned T_DS_NS  = 70,
  parameter int unsigned T_DH_NS  = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned LANES  = 2;
  localparam int unsigned RD_CYC = max_u(max_u(max_u(ns_to_cyc(T_RC_NS, CLK_NS),
                                                     ns_to_cyc(T_AA_NS, CLK_NS)),
                                               max_u(ns_to_cyc(T_ACE_NS, CLK_NS),
                                                     ns_to_cyc(T_DOE_NS, CLK_NS))),
                                         ns_to_cyc(T_BA_NS, CLK_NS));
  localparam int unsigned WR_CYC = max_u(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int unsigned HD_CYC = ns_to_cyc(T_DH_NS, CLK_NS);
  localparam int unsigned TA_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WR_CYC), max_u(HD_CYC, TA_CYC));
  localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] HD_LOAD = CNT_W'(HD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'(TA_CYC - 1);

  ctrl_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_q, rsp_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_done;
  logic              capture;
  logic              accept;
  logic              selected;
  logic [LANES-1:0]  strobe_n;

  assign accept = req_valid && (state_q == ST_IDLE);

  // Phase sequencing
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    rsp_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = req_write ? ST_WRITE : ST_READ;
          tmr_load = 1'b1;
          tmr_val  = req_write ? WR_LOAD : RD_LOAD;
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          capture  = 1'b1;
          rsp_d    = 1'b1;
          state_d  = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = TA_LOAD;
        end
      end
      ST_WRITE: begin
        if (tmr_done) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HD_LOAD;
        end
      end
      ST_HOLD: begin
        if (tmr_done) begin
          rsp_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_TURN: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= rsp_d;
      if (accept) begin
        addr_q  <= req_addr;
        be_q    <= req_be;
        wdata_q <= req_wdata;
      end
    end
  end

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign selected = (state_q == ST_READ) || (state_q == ST_WRITE) || (state_q == ST_HOLD);

  sram_lane_strobe #(.LANES(LANES)) u_strobe (
    .active   (selected),
    .lane_en  (be_q),
    .strobe_n (strobe_n)
  );

  sram_data_path #(.DATA_W(DATA_W), .LANES(LANES)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .drive   (state_q == ST_WRITE),
    .wdata   (wdata_q),
    .capture (capture),
    .lane_en (be_q),
    .dq_in   (sram_dq_in),
    .dq_out  (sram_dq_out),
    .dq_oe   (sram_dq_oe),
    .rdata   (rsp_rdata)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_q;
  assign sram_addr = addr_q;
  assign sram_ce_n = ~selected;
  assign sram_oe_n = ~(state_q == ST_READ);
  assign sram_we_n = ~(state_q == ST_WRITE);
  assign sram_lb_n = strobe_n[0];
  assign sram_ub_n = strobe_n[1];

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned T_HZ_NS = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n,
  input logic              sram_dq_oe
);

  localparam int unsigned TA_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int unsigned SW     = $clog2(TA_CYC + 2);

  logic [SW-1:0] since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_oe <= SW'(TA_CYC);
    else if (!sram_oe_n) since_oe <= '0;
    else if (since_oe < SW'(TA_CYC)) since_oe <= since_oe + 1'b1;
  end

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_ub_n && sram_lb_n && !sram_dq_oe));

  assert_busy_no_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> !req_ready);

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !$past(sram_ce_n)) |-> $stable(sram_addr));

  assert_drive_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n && !sram_ce_n && sram_oe_n));

  assert_we_rise_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_ub_n) && $stable(sram_lb_n) && !sram_ce_n));

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (since_oe >= SW'(TA_CYC)));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .CLK_NS  (CLK_NS),
  .T_HZ_NS (T_HZ_NS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_ub_n  (sram_ub_n),
  .sram_lb_n  (sram_lb_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;
  logic [15:0] sram_dq_out;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_in;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // Memory model: 256 words indexed by the low address byte; undriven lanes read 0xEE.
  logic [15:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
      if (!sram_lb_n) mem[sram_addr[7:0]][7:0]  <= sram_dq_out[7:0];
      if (!sram_ub_n) mem[sram_addr[7:0]][15:8] <= sram_dq_out[15:8];
    end
  end

  always_comb begin
    logic rd;
    rd = !sram_ce_n && sram_we_n && !sram_oe_n;
    sram_dq_in[7:0]  = (rd && !sram_lb_n) ? mem[sram_addr[7:0]][7:0]  : 8'hEE;
    sram_dq_in[15:8] = (rd && !sram_ub_n) ? mem[sram_addr[7:0]][15:8] : 8'hEE;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {write, addr[16:0], be[1:0], wdata[15:0], expected rdata[15:0]}
  localparam int NV = 13;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 17'h00010, 2'b11, 16'hA5C3, 16'h0000},
    {1'b0, 17'h00010, 2'b11, 16'h0000, 16'hA5C3},
    {1'b1, 17'h00010, 2'b01, 16'h1234, 16'h0000},
    {1'b0, 17'h00010, 2'b11, 16'h0000, 16'hA534},
    {1'b1, 17'h00010, 2'b10, 16'h7700, 16'h0000},
    {1'b0, 17'h00010, 2'b11, 16'h0000, 16'h7734},
    {1'b0, 17'h00010, 2'b01, 16'h0000, 16'h0034},
    {1'b0, 17'h00010, 2'b10, 16'h0000, 16'h7700},
    {1'b1, 17'h1FF22, 2'b11, 16'hBEEF, 16'h0000},
    {1'b0, 17'h1FF22, 2'b11, 16'h0000, 16'hBEEF},
    {1'b1, 17'h00022, 2'b00, 16'h0000, 16'h0000},
    {1'b0, 17'h1FF22, 2'b11, 16'h0000, 16'hBEEF},
    {1'b0, 17'h00010, 2'b00, 16'h0000, 16'h0000}
  };

  task automatic run_op(input logic [51:0] v);
    logic        w;
    logic [16:0] a;
    logic [1:0]  be;
    logic [15:0] wd, ex;
    int n;
    w = v[51]; a = v[50:34]; be = v[33:32]; wd = v[31:16]; ex = v[15:0];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    // Change the request inputs after acceptance: must have no effect (R2)
    req_valid = 1'b0; req_addr = ~a; req_be = ~be; req_wdata = ~wd; req_write = ~w;
    n = 1;
    chk(req_ready == 1'b0, "R2 ready low while busy", 32'(req_ready), 32'd0);
    chk(sram_addr == a, "R3 address captured", 32'(sram_addr), 32'(a));
    chk({sram_ub_n, sram_lb_n} == ~be, "R3 lane strobes", 32'({sram_ub_n, sram_lb_n}), 32'(~be));
    if (w) begin
      chk({sram_ce_n, sram_we_n, sram_oe_n} == 3'b001, "R6 write controls ce/we/oe",
          32'({sram_ce_n, sram_we_n, sram_oe_n}), 32'b001);
      chk(sram_dq_oe && sram_dq_out == wd, "R6 write data driven", 32'({sram_dq_oe, sram_dq_out}), 32'({1'b1, wd}));
    end else begin
      chk({sram_ce_n, sram_we_n, sram_oe_n} == 3'b010, "R3 read controls ce/we/oe",
          32'({sram_ce_n, sram_we_n, sram_oe_n}), 32'b010);
    end
    while (n < 20 && !rsp_valid) begin
      @(negedge clk);
      n++;
      if (w && n == 5) begin
        chk(sram_we_n && !sram_ce_n && !sram_dq_oe && sram_addr == a && {sram_ub_n, sram_lb_n} == ~be,
            "R7 hold phase after we rises", 32'({sram_we_n, sram_ce_n, sram_dq_oe}), 32'b100);
      end
    end
    if (w) begin
      chk(n == 9, "R7 write completion cycle", 32'(n), 32'd9);
      chk(req_ready == 1'b1, "R7 idle with completion", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R10 single pulse", 32'(rsp_valid), 32'd0);
    end else begin
      chk(n == 5, "R4 read completion cycle", 32'(n), 32'd5);
      chk(rsp_rdata == ex, "R4 R5 read data", 32'(rsp_rdata), 32'(ex));
      chk(sram_ce_n && sram_oe_n, "R9 controls released in turnaround", 32'({sram_ce_n, sram_oe_n}), 32'b11);
      @(negedge clk);
      chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R9 R10 turnaround blocks, pulse ends",
          32'({req_ready, rsp_valid}), 32'd0);
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 ready after turnaround", 32'(req_ready), 32'd1);
      chk(rsp_rdata == ex, "R10 read data held", 32'(rsp_rdata), 32'(ex));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (R2 access never completed)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R1)
    chk({sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n} == 5'b11111, "R1 controls high in reset",
        32'({sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n}), 32'h1F);
    chk(!sram_dq_oe && !rsp_valid, "R1 no drive, no response in reset", 32'({sram_dq_oe, rsp_valid}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && sram_ce_n && !sram_dq_oe, "R1 idle standby", 32'({req_ready, sram_ce_n, sram_dq_oe}), 32'b110);

    for (int i = 0; i < NV; i++) run_op(VEC[i]);

    // R8: partial-lane and empty-lane writes, seen through memory contents
    chk(mem[8'h10] == 16'h7734, "R8 single-lane writes kept other lane", 32'(mem[8'h10]), 32'h7734);
    chk(mem[8'h22] == 16'hBEEF, "R8 empty lane enable wrote nothing", 32'(mem[8'h22]), 32'hBEEF);

    // R11: reset in the middle of a write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00055; req_be = 2'b11; req_wdata = 16'h4242;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n} == 5'b11111 && !sram_dq_oe,
        "R11 reset mid-write releases controls",
        32'({sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, sram_dq_oe}), 32'b111110);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 reset returns to idle", 32'({req_ready, rsp_valid}), 32'b10);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_op({1'b1, 17'h00066, 2'b11, 16'h5A5A, 16'h0000});
    run_op({1'b0, 17'h00066, 2'b11, 16'h0000, 16'h5A5A});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule